// File: doc/BRIEF.md
# Repeating Block Copy Engine

This block moves a run of bytes from one region of a 16-bit address space to another. It behaves like a repeating load-and-increment instruction. A one-cycle start pulse loads a source pointer, a destination pointer and a byte count. For each byte the engine then reads the source location and writes that byte to the destination location. It then steps both pointers up by one and the count down by one. It keeps going until the count reaches zero. The three registers are visible on outputs throughout, so the surrounding processor sees the same values it would see after each repetition.

Each byte uses a fixed cycle budget. A byte that is followed by another repetition takes 21 clocks. The byte that brings the count to zero takes 16 clocks. A 6144-byte copy therefore takes 21·6143+16 clocks. The operation clears three status flags: half-carry, parity/overflow and subtract. Those flags are held in the block. They come out of reset set, and they stay cleared once any byte has been moved.

The memory side is a synchronous single-port interface. The read strobe and write strobe are never raised together. Read data is valid exactly one cycle after the read strobe. Every write is accepted in the cycle its strobe is high. The interface has no back-pressure: the memory may not stall, and the engine never waits, so the cycle budget is exact.

Top module: `blkcopy_engine`

## Requirements
- R1: A start pulse while idle loads the source, destination and count inputs. In the cycle after the start is sampled, busy is high and the three register outputs show the loaded values.
- R2: Each byte raises the read strobe for one cycle with the source pointer on the address. Two cycles later it raises the write strobe for one cycle with the destination pointer on the address. The write data is the byte that the memory returned one cycle after the read strobe.
- R3: In the cycle after each write strobe, the source output is one higher, the destination output is one higher and the count output is one lower than before that byte.
- R4: Bytes repeat until the count output is zero after an update. The engine then stops, and exactly as many writes have been made as the count that was loaded.
- R5: Read strobes of consecutive bytes are 21 cycles apart. Busy is high for 21·(N−1)+16 cycles for an N-byte copy.
- R6: Done is high for exactly one cycle, in the first cycle with busy low after a copy. The count output is zero in that cycle.
- R7: The half-carry, parity/overflow and subtract flag outputs are 1 after reset. They are 0 from the cycle after the first byte's write onward.
- R8: A start with a count of zero copies 2^16 bytes: the count becomes all ones after the first byte.
- R9: The source and destination pointers wrap from all ones to zero.
- R10: A start pulse while busy is ignored: the copy finishes with the values loaded by the first start.
- R11: Copying 6144 bytes from 0x8000 to 0x4000 ends with source 0x9800, destination 0x5800 and count 0.
- R12: During and after reset, busy, done and both strobes are low and the three register outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a copy |
| src_in | input | 16 | Source pointer loaded at start |
| dst_in | input | 16 | Destination pointer loaded at start |
| cnt_in | input | 16 | Byte count loaded at start (0 means 65536) |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid one cycle after mem_rd |
| src_q | output | 16 | Current source pointer |
| dst_q | output | 16 | Current destination pointer |
| cnt_q | output | 16 | Remaining byte count |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle end-of-copy pulse |
| flag_half | output | 1 | Half-carry flag |
| flag_pv | output | 1 | Parity/overflow flag |
| flag_sub | output | 1 | Subtract flag |

## Verification
A phase counter that is out of step appears at the ports within one byte. The gap from a read strobe to its write strobe stops being two cycles, or the gap between successive reads stops being 21 cycles. A wrong pointer appears on the address of the very next strobe, and on the register outputs the cycle after that byte's write. A wrong count is the slowest fault to show. It shows as a wrong count output after each byte. At the end it shows as a wrong number of writes, a wrong busy length, or done arriving while the count is not zero.

// File: rtl/blkcopy_pkg.sv
package blkcopy_pkg;

  // Status flags that the copy operation forces low.
  typedef struct packed {
    logic half;
    logic pv;
    logic sub;
  } cp_flags_t;

  localparam cp_flags_t FLAGS_RESET = '{half: 1'b1, pv: 1'b1, sub: 1'b1};

  // Larger of the two per-byte budgets; it sizes the phase counter.
  function automatic int unsigned max_budget(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/blkcopy_timer.sv
module blkcopy_timer #(
  parameter int unsigned REP_CYC  = 21,
  parameter int unsigned LAST_CYC = 16,
  parameter int unsigned PH_W     = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            run,
  input  logic            final_byte,
  output logic [PH_W-1:0] ph,
  output logic            rd_slot,
  output logic            cap_slot,
  output logic            wr_slot,
  output logic            byte_end
);

  localparam logic [PH_W-1:0] REP_END  = PH_W'(REP_CYC - 1);
  localparam logic [PH_W-1:0] LAST_END = PH_W'(LAST_CYC - 1);
  localparam logic [PH_W-1:0] PH_ONE   = PH_W'(1);
  localparam logic [PH_W-1:0] PH_TWO   = PH_W'(2);

  logic [PH_W-1:0] ph_q;
  logic            at_end;

  // When the two budgets are equal, a single comparator is enough.
  generate
    if (REP_CYC == LAST_CYC) begin : g_one_budget
      always_comb at_end = (ph_q == REP_END);
    end else begin : g_two_budgets
      always_comb at_end = final_byte ? (ph_q == LAST_END) : (ph_q == REP_END);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q <= '0;
    end else if (clr) begin
      ph_q <= '0;
    end else if (run) begin
      ph_q <= at_end ? '0 : ph_q + PH_ONE;
    end
  end

  always_comb begin
    ph       = ph_q;
    rd_slot  = run && (ph_q == '0);
    cap_slot = run && (ph_q == PH_ONE);
    wr_slot  = run && (ph_q == PH_TWO);
    byte_end = run && at_end;
  end

  // R5
  // phase_bound_chk
  phase_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (ph_q <= REP_END));

  // R5
  // last_budget_chk
  last_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && final_byte && ph_q > PH_TWO) |-> (ph_q <= LAST_END));

endmodule

// File: rtl/blkcopy_ptrs.sv
module blkcopy_ptrs #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] src_in,
  input  logic [W-1:0] dst_in,
  input  logic [W-1:0] cnt_in,
  output logic [W-1:0] src_q,
  output logic [W-1:0] dst_q,
  output logic [W-1:0] cnt_q,
  output logic         cnt_zero
);

  localparam int unsigned NREG = 3;
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] init_v [NREG];
  logic [W-1:0] reg_q  [NREG];

  always_comb begin
    init_v[0] = src_in;
    init_v[1] = dst_in;
    init_v[2] = cnt_in;
  end

  // Index 0 and 1 are pointers that count up; index 2 is the count going down.
  generate
    for (genvar i = 0; i < NREG; i++) begin : g_reg
      localparam bit DOWN = (i == NREG - 1);
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          reg_q[i] <= '0;
        end else if (load) begin
          reg_q[i] <= init_v[i];
        end else if (step) begin
          reg_q[i] <= DOWN ? (reg_q[i] - ONE) : (reg_q[i] + ONE);
        end
      end
    end
  endgenerate

  always_comb begin
    src_q    = reg_q[0];
    dst_q    = reg_q[1];
    cnt_q    = reg_q[2];
    cnt_zero = (reg_q[2] == '0);
  end

  // R3
  // ptr_step_chk
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (src_q == $past(src_q) + ONE) && (dst_q == $past(dst_q) + ONE)
                        && (cnt_q == $past(cnt_q) - ONE));

  // R1
  // ptr_load_chk
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (src_q == $past(src_in)) && (dst_q == $past(dst_in)) && (cnt_q == $past(cnt_in)));

endmodule

// File: rtl/blkcopy_flags.sv
module blkcopy_flags
  import blkcopy_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      step,
  output cp_flags_t flags
);

  cp_flags_t flags_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= FLAGS_RESET;
    end else if (step) begin
      flags_q <= '{half: 1'b0, pv: 1'b0, sub: 1'b0};
    end
  end

  assign flags = flags_q;

  // R7
  // flags_clear_chk
  flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (flags_q == '0));

  // R7
  // flags_hold_chk
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q == '0) |=> (flags_q == '0));

endmodule

// File: rtl/blkcopy_engine.sv
module blkcopy_engine
  import blkcopy_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned REP_CYC  = 21,
  parameter int unsigned LAST_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] src_in,
  input  logic [ADDR_W-1:0] dst_in,
  input  logic [ADDR_W-1:0] cnt_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] src_q,
  output logic [ADDR_W-1:0] dst_q,
  output logic [ADDR_W-1:0] cnt_q,
  output logic              busy,
  output logic              done,
  output logic              flag_half,
  output logic              flag_pv,
  output logic              flag_sub
);

  localparam int unsigned PH_W = $clog2(max_budget(REP_CYC, LAST_CYC));

  logic              busy_q;
  logic              done_q;
  logic              accept;
  logic              cnt_zero;
  logic [PH_W-1:0]   ph;
  logic              rd_slot;
  logic              cap_slot;
  logic              wr_slot;
  logic              byte_end;
  logic [DATA_W-1:0] data_q;
  cp_flags_t         flags;

  // A start is taken only when the engine is idle.
  assign accept = start && !busy_q;

  blkcopy_timer #(
    .REP_CYC (REP_CYC),
    .LAST_CYC(LAST_CYC),
    .PH_W    (PH_W)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (accept),
    .run       (busy_q),
    .final_byte(cnt_zero),
    .ph        (ph),
    .rd_slot   (rd_slot),
    .cap_slot  (cap_slot),
    .wr_slot   (wr_slot),
    .byte_end  (byte_end)
  );

  blkcopy_ptrs #(
    .W(ADDR_W)
  ) u_ptrs (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .step    (wr_slot),
    .src_in  (src_in),
    .dst_in  (dst_in),
    .cnt_in  (cnt_in),
    .src_q   (src_q),
    .dst_q   (dst_q),
    .cnt_q   (cnt_q),
    .cnt_zero(cnt_zero)
  );

  blkcopy_flags u_flags (
    .clk  (clk),
    .rst_n(rst_n),
    .step (wr_slot),
    .flags(flags)
  );

  // Engine control: run from an accepted start to the end of the last byte.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
      end else if (byte_end && cnt_zero) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  // The byte returned by memory is held until the write slot.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (cap_slot) begin
      data_q <= mem_rdata;
    end
  end

  always_comb begin
    mem_rd    = rd_slot;
    mem_wr    = wr_slot;
    mem_addr  = wr_slot ? dst_q : src_q;
    mem_wdata = data_q;
    busy      = busy_q;
    done      = done_q;
    flag_half = flags.half;
    flag_pv   = flags.pv;
    flag_sub  = flags.sub;
  end

  // R2
  // rd_wr_order_chk
  rd_wr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> ##2 (mem_wr && (mem_addr == dst_q)));

  // R6
  // done_pulse_chk
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && cnt_q == '0) ##1 !done);

  // R4
  // stop_at_zero_chk
  stop_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (cnt_q == '0) && done);

  // R10
  // busy_start_chk
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !mem_wr) |=> $stable(src_q) && $stable(dst_q) && $stable(cnt_q));

endmodule

// File: tb/blkcopy_engine_bench.sv
module blkcopy_engine_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;
  localparam int REP        = 21;
  localparam int LAST       = 16;

  // {source, destination, count}
  localparam logic [47:0] VECS [0:3] = '{
    48'h1000_2000_0001,
    48'h0100_0300_0003,
    48'hFFFE_0010_0004,
    48'h0020_FFFD_0005
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  // ---------------- main 16-bit instance ----------------
  logic        start = 1'b0;
  logic [15:0] src_in = '0, dst_in = '0, cnt_in = '0;
  logic [15:0] mem_addr, src_q, dst_q, cnt_q;
  logic        mem_rd, mem_wr, busy, done, flag_half, flag_pv, flag_sub;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;

  blkcopy_engine u_blkcopy_engine (
    .clk(clk), .rst_n(rst_n), .start(start),
    .src_in(src_in), .dst_in(dst_in), .cnt_in(cnt_in),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q),
    .busy(busy), .done(done),
    .flag_half(flag_half), .flag_pv(flag_pv), .flag_sub(flag_sub)
  );

  function automatic logic [7:0] mem_fn(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= mem_fn(mem_addr);

  // ---------------- narrow 8-bit instance for the zero-count case ----------------
  logic       start8 = 1'b0;
  logic [7:0] src8_in = '0, dst8_in = '0, cnt8_in = '0;
  logic [7:0] addr8, src8_q, dst8_q, cnt8_q, wdata8;
  logic [7:0] rdata8 = '0;
  logic       rd8, wr8, busy8, done8, fh8, fp8, fs8;

  blkcopy_engine #(.ADDR_W(8)) u_blkcopy_engine_w8 (
    .clk(clk), .rst_n(rst_n), .start(start8),
    .src_in(src8_in), .dst_in(dst8_in), .cnt_in(cnt8_in),
    .mem_addr(addr8), .mem_rd(rd8), .mem_wr(wr8),
    .mem_wdata(wdata8), .mem_rdata(rdata8),
    .src_q(src8_q), .dst_q(dst8_q), .cnt_q(cnt8_q),
    .busy(busy8), .done(done8),
    .flag_half(fh8), .flag_pv(fp8), .flag_sub(fs8)
  );

  always @(posedge clk) if (rd8) rdata8 <= addr8 ^ 8'hA5;

  // ---------------- monitors ----------------
  int          rd_cnt, wr_cnt, xfer_err, upd_err, gap_err, busy_cyc;
  int          since_rd = -1;
  logic        pend = 1'b0;
  logic [15:0] exp_src, exp_dst, exp_cnt;

  always @(negedge clk) begin
    if (busy) busy_cyc++;
    if (pend) begin
      if (src_q !== exp_src || dst_q !== exp_dst || cnt_q !== exp_cnt) upd_err++;
      pend = 1'b0;
    end
    if (since_rd >= 0) since_rd++;
    if (mem_rd) begin
      if (mem_addr !== exp_src) xfer_err++;
      if (rd_cnt > 0 && since_rd != REP) gap_err++;
      since_rd = 0;
      rd_cnt++;
    end
    if (mem_wr) begin
      if (mem_addr !== exp_dst || mem_wdata !== mem_fn(exp_src) || since_rd != 2) xfer_err++;
      wr_cnt++;
      exp_src++;
      exp_dst++;
      exp_cnt--;
      pend = 1'b1;
    end
  end

  int         wr8_cnt, err8, busy8_cyc;
  logic       pend8 = 1'b0;
  logic [7:0] exp8_src, exp8_dst, first_cnt8;

  always @(negedge clk) begin
    if (busy8) busy8_cyc++;
    if (pend8) begin
      if (wr8_cnt == 1) first_cnt8 = cnt8_q;
      pend8 = 1'b0;
    end
    if (wr8) begin
      if (addr8 !== exp8_dst || wdata8 !== (exp8_src ^ 8'hA5)) err8++;
      wr8_cnt++;
      exp8_src++;
      exp8_dst++;
      pend8 = 1'b1;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_copy(input logic [15:0] s, input logic [15:0] d,
                          input logic [15:0] c, input int inject);
    int n;
    n = int'(c);
    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0; xfer_err = 0; upd_err = 0; gap_err = 0; busy_cyc = 0;
    since_rd = -1; exp_src = s; exp_dst = d; exp_cnt = c;
    src_in = s; dst_in = d; cnt_in = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R1: loaded values visible the cycle after start
    check(busy === 1'b1 && src_q === s && dst_q === d && cnt_q === c, "R1", "load",
          {src_q, dst_q, cnt_q}, {s, d, c});
    if (inject > 0) begin
      repeat (inject) @(negedge clk);
      src_in = 16'h7777; dst_in = 16'h6666; cnt_in = 16'h0002; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (done !== 1'b1) @(negedge clk);
    check(busy === 1'b0 && cnt_q === 16'h0, "R6", "done with busy low, count zero",
          {busy, cnt_q}, 17'h0);
    check(wr_cnt == n, "R4", "write count", wr_cnt, n);
    check(src_q === s + c && dst_q === d + c, "R3", "final pointers",
          {src_q, dst_q}, {s + c, d + c});
    check(xfer_err == 0, "R2", "read/write address, data, spacing", xfer_err, 0);
    check(upd_err == 0, "R3", "per-byte register step", upd_err, 0);
    check(busy_cyc == REP * (n - 1) + LAST, "R5", "busy cycles", busy_cyc, REP * (n - 1) + LAST);
    check(gap_err == 0, "R5", "read-to-read gap", gap_err, 0);
    check({flag_half, flag_pv, flag_sub} === 3'b000, "R7", "flags cleared",
          {flag_half, flag_pv, flag_sub}, 0);
    @(negedge clk);
    check(done === 1'b0, "R6", "done lasts one cycle", done, 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    check(busy === 1'b0 && done === 1'b0 && mem_rd === 1'b0 && mem_wr === 1'b0,
          "R12", "control in reset", {busy, done, mem_rd, mem_wr}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(src_q === 16'h0 && dst_q === 16'h0 && cnt_q === 16'h0 && busy === 1'b0,
          "R12", "registers after reset", {src_q, dst_q, cnt_q}, 0);
    // R7: flags set out of reset
    check({flag_half, flag_pv, flag_sub} === 3'b111, "R7", "flags after reset",
          {flag_half, flag_pv, flag_sub}, 3'b111);

    // Table walk; R9 covered by wrapping source (entry 2) and destination (entry 3)
    for (int i = 0; i < 4; i++) begin
      run_copy(VECS[i][47:32], VECS[i][31:16], VECS[i][15:0], 0);
    end

    // R10: start while busy, injected mid-copy, must be ignored
    run_copy(16'h0400, 16'h0500, 16'h0008, 30);
    check(src_q === 16'h0408 && dst_q === 16'h0508, "R10", "late start ignored",
          {src_q, dst_q}, {16'h0408, 16'h0508});

    // R11: the 6144-byte copy
    run_copy(16'h8000, 16'h4000, 16'd6144, 0);
    check(src_q === 16'h9800 && dst_q === 16'h5800 && cnt_q === 16'h0, "R11", "large copy end",
          {src_q, dst_q, cnt_q}, {16'h9800, 16'h5800, 16'h0});

    // R8: zero count means full range (narrow instance, 256 bytes)
    @(negedge clk);
    wr8_cnt = 0; err8 = 0; busy8_cyc = 0; exp8_src = 8'h10; exp8_dst = 8'h90;
    first_cnt8 = 8'h00;
    src8_in = 8'h10; dst8_in = 8'h90; cnt8_in = 8'h00; start8 = 1'b1;
    @(negedge clk);
    start8 = 1'b0;
    while (done8 !== 1'b1) @(negedge clk);
    check(first_cnt8 === 8'hFF, "R8", "count after first byte", first_cnt8, 8'hFF);
    check(wr8_cnt == 256 && err8 == 0, "R8", "full-range writes", wr8_cnt, 256);
    check(busy8_cyc == REP * 255 + LAST, "R8", "full-range busy cycles", busy8_cyc, REP * 255 + LAST);
    // R9: full wrap returns pointers to their start
    check(src8_q === 8'h10 && dst8_q === 8'h90 && cnt8_q === 8'h00, "R9", "pointer wrap",
          {src8_q, dst8_q, cnt8_q}, {8'h10, 8'h90, 8'h00});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule